// File: doc/BRIEF.md
# Feedback Shift-Bus Master Sequencer

This block is the master of a daisy-chained feedback bus. The bus has three control outputs: a bit clock, a capture strobe and a chain reset. It has one serial data input. Each slave on the chain holds an 8-bit parallel-in register, and all the slaves together act as one long shift register. When a start pulse arrives, the sequencer first makes every slave latch its inputs. It then pulses the chain reset and shifts out a chosen number of slave bytes. Each byte reaches the rest of the chip on a valid/ready stream.

The bit timing comes from the system clock frequency given as a parameter. There is a nominal rate of 5 kHz and a slower rate for long cabling, picked by an input at start. The capture hold time is also derived from the system clock. Before the first clock of each bit, the sequencer samples the data line once, in the middle of the clock-low half. It shifts each bit into the byte MSB first. When the stream sink is not ready, the sequencer stalls with the bit clock held high.

Top module: `fbus_master`

## Requirements
- R1: After reset and whenever no scan runs, fb_clk is 1, fb_load, fb_reset, rx_valid and busy are 0.
- R2: In the cycle after a start is accepted, fb_clk goes low for H cycles with fb_load low. fb_load then goes high with fb_clk still low for HOLD_CYC cycles. After that, fb_clk rises while fb_load is high. H is the half bit period in system clocks.
- R3: After the capture edge, fb_clk and fb_load stay high for 2H cycles. fb_reset is then 1 for 2H cycles, and fb_load stays high for a further 2H cycles after fb_reset falls. fb_load and fb_reset stay 0 for the rest of the scan.
- R4: Each bit is fb_clk low for H cycles, then high for H cycles. fb_data is captured once per bit, at the clock edge that ends low-phase cycle number floor(H/2), counting from 0.
- R5: The first bit captured for a byte becomes bit 7 of rx_byte and the eighth becomes bit 0. rx_byte presents the completed byte while rx_valid is 1.
- R6: A scan delivers num_slaves bytes. A value of 0 counts as 1, and a value above MAX_SLAVES counts as MAX_SLAVES.
- R7: rx_valid rises in the cycle after the eighth high phase of a byte ends. While rx_ready is 0, rx_valid, rx_byte and fb_clk=1 hold. The next byte's low phase begins in the cycle after the handshake.
- R8: busy rises in the cycle after an accepted start and falls in the cycle after the last byte's handshake. While busy is 1, start pulses are ignored.
- R9: sel_slow=1 at start selects H=CLK_HZ/(2*SLOW_HZ), otherwise H=CLK_HZ/(2*FAST_HZ). Changes of sel_slow during a scan have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request, taken only while idle |
| sel_slow | input | 1 | Select the slow bit rate for the next scan |
| num_slaves | input | NW | Number of slave bytes to read |
| fb_clk | output | 1 | Bus bit clock, idles high |
| fb_load | output | 1 | Bus capture strobe |
| fb_reset | output | 1 | Bus chain reset |
| fb_data | input | 1 | Serial data from the chain |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | rx_byte holds a byte |
| rx_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | Scan in progress |

## Verification
A wrong phase counter or a wrong duration load shows in the very next cycle as a bus control level that differs from the cycle-by-cycle model. A wrong sample point or a wrong bit order leaves the control waveform intact, so it only shows as a mismatching rx_byte when that byte is presented. A wrong byte count or a lost stall becomes visible at the end of the first byte or the first stalled cycle: rx_valid, busy or fb_clk is then wrong.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_HOLD,
    S_CAPT,
    S_RST,
    S_POST,
    S_LOW,
    S_HIGH,
    S_VALID
  } fbus_state_e;
endpackage

// File: rtl/fbus_timer.sv
module fbus_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic [TW-1:0] cnt,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ld)          cnt <= ld_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fbus_sampler.sv
module fbus_sampler #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          din,
  output logic [BW-1:0] word
);
  // first captured bit ends up in the most significant position
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= {word[BW-2:0], din};
  end
endmodule

// File: rtl/fbus_master.sv
module fbus_master
  import fbus_pkg::*;
#(
  parameter int CLK_HZ     = 1_000_000,
  parameter int FAST_HZ    = 5000,
  parameter int SLOW_HZ    = 1300,
  parameter int HOLD_US    = 100,
  parameter int MAX_SLAVES = 32,
  parameter int NW         = $clog2(MAX_SLAVES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sel_slow,
  input  logic [NW-1:0] num_slaves,
  output logic          fb_clk,
  output logic          fb_load,
  output logic          fb_reset,
  input  logic          fb_data,
  output logic [7:0]    rx_byte,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          busy
);
  localparam int HALF_FAST = CLK_HZ / (2 * FAST_HZ);
  localparam int HALF_SLOW = CLK_HZ / (2 * SLOW_HZ);
  localparam int HOLD_CYC  = (CLK_HZ / 1000) * HOLD_US / 1000;
  localparam int HMAX      = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int DMAX      = (2 * HMAX > HOLD_CYC) ? 2 * HMAX : HOLD_CYC;
  localparam int TW        = $clog2(DMAX + 1);

  fbus_state_e   st, nxt;
  logic [TW-1:0] half_q, h_eff, two_h, tmr_cnt, ld_val;
  logic          tmr_ld, tmr_zero, samp;
  logic [2:0]    bit_idx;
  logic [NW-1:0] left_q, req_cnt;

  always_comb begin
    if (num_slaves == '0)                    req_cnt = NW'(1);
    else if (num_slaves > NW'(MAX_SLAVES))   req_cnt = NW'(MAX_SLAVES);
    else                                     req_cnt = num_slaves;
  end

  assign h_eff = (st == S_IDLE) ? (sel_slow ? TW'(HALF_SLOW) : TW'(HALF_FAST)) : half_q;
  assign two_h = (h_eff << 1) - 1'b1;

  always_comb begin
    nxt    = st;
    tmr_ld = 1'b0;
    ld_val = '0;
    case (st)
      S_IDLE:  if (start)    begin nxt = S_PRE;  tmr_ld = 1'b1; ld_val = h_eff - 1'b1; end
      S_PRE:   if (tmr_zero) begin nxt = S_HOLD; tmr_ld = 1'b1; ld_val = TW'(HOLD_CYC - 1); end
      S_HOLD:  if (tmr_zero) begin nxt = S_CAPT; tmr_ld = 1'b1; ld_val = two_h; end
      S_CAPT:  if (tmr_zero) begin nxt = S_RST;  tmr_ld = 1'b1; ld_val = two_h; end
      S_RST:   if (tmr_zero) begin nxt = S_POST; tmr_ld = 1'b1; ld_val = two_h; end
      S_POST:  if (tmr_zero) begin nxt = S_LOW;  tmr_ld = 1'b1; ld_val = h_eff - 1'b1; end
      S_LOW:   if (tmr_zero) begin nxt = S_HIGH; tmr_ld = 1'b1; ld_val = h_eff - 1'b1; end
      S_HIGH:  if (tmr_zero) begin
                 if (bit_idx == 3'd7) nxt = S_VALID;
                 else begin nxt = S_LOW; tmr_ld = 1'b1; ld_val = h_eff - 1'b1; end
               end
      S_VALID: if (rx_ready) begin
                 if (left_q == NW'(1)) nxt = S_IDLE;
                 else begin nxt = S_LOW; tmr_ld = 1'b1; ld_val = h_eff - 1'b1; end
               end
      default: nxt = S_IDLE;
    endcase
  end

  // one capture per bit, at the middle of the clock-low half
  assign samp = (st == S_LOW) && (tmr_cnt == (half_q - 1'b1 - (half_q >> 1)));

  fbus_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .ld     (tmr_ld),
    .ld_val (ld_val),
    .cnt    (tmr_cnt),
    .zero   (tmr_zero)
  );

  fbus_sampler #(.BW(8)) u_smp (
    .clk  (clk),
    .rst  (rst),
    .en   (samp),
    .din  (fb_data),
    .word (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      half_q   <= TW'(HALF_FAST);
      bit_idx  <= '0;
      left_q   <= '0;
      fb_clk   <= 1'b1;
      fb_load  <= 1'b0;
      fb_reset <= 1'b0;
      rx_valid <= 1'b0;
      busy     <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        half_q  <= h_eff;
        left_q  <= req_cnt;
        bit_idx <= '0;
      end
      if (st == S_HIGH && tmr_zero) bit_idx <= bit_idx + 1'b1;
      if (st == S_VALID && rx_ready) left_q <= left_q - 1'b1;
      fb_clk   <= !(nxt == S_PRE || nxt == S_HOLD || nxt == S_LOW);
      fb_load  <= (nxt == S_HOLD || nxt == S_CAPT || nxt == S_RST || nxt == S_POST);
      fb_reset <= (nxt == S_RST);
      rx_valid <= (nxt == S_VALID);
      busy     <= (nxt != S_IDLE);
    end
  end
endmodule

// File: rtl/fbus_master_chk.sv
module fbus_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       fb_clk,
  input logic       fb_load,
  input logic       fb_reset,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       busy
);
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (fb_clk && !fb_load && !fb_reset && !rx_valid));

  p_load_rise_clk_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_load) |-> !fb_clk);

  p_reset_inside_load_r3: assert property (@(posedge clk) disable iff (rst)
    fb_reset |-> (fb_load && fb_clk));

  p_load_outlasts_reset_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fb_reset) |-> fb_load);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_byte) && fb_clk));

  p_valid_clk_high_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (fb_clk && !fb_load));

  p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> busy);

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind fbus_master fbus_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .fb_clk   (fb_clk),
  .fb_load  (fb_load),
  .fb_reset (fb_reset),
  .rx_byte  (rx_byte),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .busy     (busy)
);

// File: tb/sim_fbus_master.sv
module sim_fbus_master;
  localparam int CLK_PERIOD = 10;
  localparam int HF   = 4;    // 40000 / (2*5000)
  localparam int HS   = 7;    // 40000 / (2*2800)
  localparam int HOLD = 10;   // 40 * 250 / 1000
  localparam int MAXS = 32;
  localparam int NW   = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sel_slow = 1'b0;
  logic rx_ready = 1'b1, fb_data = 1'b0;
  logic [NW-1:0] num_slaves = '0;
  logic fb_clk, fb_load, fb_reset, rx_valid, busy;
  logic [7:0] rx_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbus_master #(.CLK_HZ(40000), .FAST_HZ(5000), .SLOW_HZ(2800), .HOLD_US(250),
                .MAX_SLAVES(MAXS)) u0 (
    .clk(clk), .rst(rst), .start(start), .sel_slow(sel_slow), .num_slaves(num_slaves),
    .fb_clk(fb_clk), .fb_load(fb_load), .fb_reset(fb_reset), .fb_data(fb_data),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .busy(busy));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  // slave chain model
  logic [7:0]   pat [MAXS];
  logic [7:0]   snap[MAXS];
  logic [255:0] chain = '0;
  bit           prev_clk = 1'b1;
  bit           stall_mode = 1'b0;

  // reference model state
  logic [2:0] q_sig[$];
  string      q_tag[$];
  bit         m_idle = 1'b1, m_inval = 1'b0;
  int         m_h = HF, m_left = 0, m_byte = 0, seen = 0;
  logic [2:0] exp_sig = 3'b100;   // {clk, load, reset}
  string      exp_tag = "R1";
  bit         exp_busy = 1'b0, exp_valid = 1'b0;

  function automatic int clampn(int n);
    if (n == 0) return 1;
    if (n > MAXS) return MAXS;
    return n;
  endfunction

  function automatic void push(int n, logic [2:0] s, string t);
    for (int i = 0; i < n; i++) begin q_sig.push_back(s); q_tag.push_back(t); end
  endfunction

  function automatic void push_byte();
    string t = (m_h == HS) ? "R9" : "R4";
    for (int b = 0; b < 8; b++) begin
      push(m_h, 3'b000, t);
      push(m_h, 3'b100, t);
    end
  endfunction

  function automatic void pop();
    exp_sig = q_sig.pop_front();
    exp_tag = q_tag.pop_front();
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idle = 1; m_inval = 0; exp_sig = 3'b100; exp_tag = "R1";
      exp_busy = 0; exp_valid = 0; q_sig.delete(); q_tag.delete();
    end else begin
      if (rx_valid && rx_ready) seen++;
      if (m_idle) begin
        if (start) begin
          m_idle = 0; m_byte = 0;
          m_h = sel_slow ? HS : HF;
          m_left = clampn(int'(num_slaves));
          for (int k = 0; k < MAXS; k++) snap[k] = pat[k];
          push(m_h, 3'b000, "R2");
          push(HOLD, 3'b010, "R2");
          push(2*m_h, 3'b110, "R3");
          push(2*m_h, 3'b111, "R3");
          push(2*m_h, 3'b110, "R3");
          push_byte();
          pop(); exp_busy = 1; exp_valid = 0;
        end else begin
          exp_sig = 3'b100; exp_tag = "R1"; exp_busy = 0; exp_valid = 0;
        end
      end else if (q_sig.size() > 0) begin
        pop(); exp_valid = 0;
      end else if (!m_inval) begin
        m_inval = 1; exp_valid = 1; exp_sig = 3'b100; exp_tag = "R7";
      end else if (rx_ready) begin
        m_inval = 0; exp_valid = 0; m_left--; m_byte++;
        if (m_left == 0) begin
          m_idle = 1; exp_busy = 0; exp_sig = 3'b100; exp_tag = "R8";
        end else begin
          push_byte(); pop();
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    rx_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
    if (!rst && !prev_clk && fb_clk) begin
      if (fb_load) for (int k = 0; k < MAXS; k++) chain[255 - 8*k -: 8] = pat[k];
      else         chain = {chain[254:0], 1'b0};
    end
    prev_clk = fb_clk;
    fb_data  = chain[255];
    if (!rst) begin
      chk({fb_clk, fb_load, fb_reset} == exp_sig, exp_tag, "clk/load/reset",
          int'({fb_clk, fb_load, fb_reset}), int'(exp_sig));
      chk(busy == exp_busy, "R8", "busy", int'(busy), int'(exp_busy));
      chk(rx_valid == exp_valid, "R7", "rx_valid", int'(rx_valid), int'(exp_valid));
      if (exp_valid && rx_valid)  // R5: MSB-first byte matches slave content
        chk(rx_byte == snap[m_byte], "R5", "rx_byte", int'(rx_byte), int'(snap[m_byte]));
    end
  end

  task automatic scan(int n, bit slow, bit stall, int seed, bit poke);
    for (int k = 0; k < MAXS; k++) pat[k] = 8'((seed * 53 + k * 29 + 7) ^ (k << 5));
    num_slaves = NW'(n); sel_slow = slow; stall_mode = stall; seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin  // R8/R9: start and rate change during a scan are ignored
      repeat (30) @(negedge clk);
      start = 1'b1; sel_slow = !slow;
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < 40000 && !m_idle; w++) @(negedge clk);
    chk(seen == clampn(n), "R6", "byte count", seen, clampn(n));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < MAXS; k++) pat[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset levels
    chk(fb_clk == 1'b1 && fb_load == 1'b0 && fb_reset == 1'b0, "R1", "idle bus",
        int'({fb_clk, fb_load, fb_reset}), 3'b100);
    chk(busy == 1'b0 && rx_valid == 1'b0, "R1", "idle flags", int'({busy, rx_valid}), 0);
    scan(2, 1'b0, 1'b0, 1, 1'b0);
    scan(0, 1'b0, 1'b0, 2, 1'b0);    // R6: zero counts as one
    scan(40, 1'b0, 1'b0, 3, 1'b0);   // R6: clamp to maximum
    scan(3, 1'b1, 1'b1, 4, 1'b0);    // R7 stall, R9 slow rate
    scan(4, 1'b0, 1'b1, 5, 1'b1);    // R8 ignored start, R9 latched rate
    scan(1, 1'b1, 1'b0, 6, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule